// File: doc/BRIEF.md
# Descriptor Auto-Poll Timer

This block tells a descriptor DMA engine when to re-read its descriptor ring. It raises a single poll request either at once, when software writes a poll demand, or on its own after a programmable period has run out. The period is a 4-bit timeout times a cycle unit. The unit is counted in MII clock ticks and comes in a normal length and a long length. The tick rate scales with link speed, so the unit follows the link: the normal unit is 5.12 us at 100 Mbps and 51.2 us at 10 Mbps. A timeout of zero turns self-polling off, so only software demands remain.

A chip uses two instances, one for transmit and one for receive. They differ only in the timeout loaded at reset: the receive instance starts with a timeout of 1 and the transmit instance with 0. Software reprograms the timeout and unit select through a configuration write strobe.

The request is a level. It stays high until the DMA engine acknowledges it, and any trigger that arrives while it is pending is folded into that same request. A software demand restarts the periodic countdown. So does every configuration write, which reloads the countdown from the new value.

Top module: `desc_poll_timer`

## Requirements
- R1: While reset is low, and on the first cycle after it, `poll_req_o` is 0. The configuration comes out of reset with the timeout equal to parameter `RESET_TMO` and the normal unit selected.
- R2: A cycle with `sw_poll_i` high makes `poll_req_o` 1 on the following cycle.
- R3: Once `poll_req_o` is 1 it stays 1 until a cycle with `ack_i` high. After such a cycle with no trigger, it is 0.
- R4: Triggers that arrive while a request is pending produce no second request: one acknowledge clears them all. A trigger in the same cycle as an acknowledge wins, and the request stays 1.
- R5: With a timeout of 0 the block never raises a request without a software demand.
- R6: With `cfg_long_i` = 0 (normal unit) and timeout T > 0, a periodic request is raised every T × `NORM_TICKS` (default 128) counted ticks. T = 15 is the largest period.
- R7: With `cfg_long_i` = 1 (long unit), the period is T × `LONG_TICKS` (default 2048) counted ticks.
- R8: Only cycles with `tick_i` high advance the countdown. With `tick_i` low the countdown holds its value.
- R9: A software demand restarts the countdown from zero. The next periodic request comes one full period after the demand.
- R10: A configuration write (`cfg_we_i` high) loads the timeout and unit select and restarts the countdown from zero. The write itself raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_poll_i | input | 1 | One-cycle software poll-demand strobe |
| tick_i | input | 1 | MII clock tick enable; one cycle high per tick |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_tmo_i | input | 4 | Timeout in cycle units; 0 disables self-polling |
| cfg_long_i | input | 1 | Unit select: 0 normal, 1 long |
| ack_i | input | 1 | DMA engine accepts the pending request |
| poll_req_o | output | 1 | Poll request, held until acknowledged |

## Verification
The scoreboard expects each rising edge of the request in an exact cycle, counted from the restart event. A design off by one tick in the prescaler or the unit counter therefore shows as an early or late edge, not just a missing one. The bench restarts the countdown partway through a period, once with a software demand and once with a configuration write. A design that ignored either restart would fire on the old schedule. A design that treated the write as a demand would raise a request at once. Further cases hold the tick low for a long stretch, use a zero timeout, and use the largest long-unit period; a design that counted cycles instead of ticks, or wrapped at timeout 0 or 15, would fire there. The bench also acknowledges and triggers in the same cycle, and sends several demands while one is pending. A design that let the acknowledge win would lose a poll, and one that queued demands would raise extra requests.

// File: rtl/apoll_pkg.sv
// Shared types for the descriptor auto-poll timer.
// Assumes: the timeout field width is fixed for every instance of the block.
package apoll_pkg;

    localparam int POLL_TMO_W = 4;

    typedef logic [POLL_TMO_W-1:0] poll_tmo_t;

    typedef enum logic [0:0] {
        UNIT_NORMAL = 1'b0,
        UNIT_LONG   = 1'b1
    } unit_sel_e;

    typedef struct packed {
        unit_sel_e unit;
        poll_tmo_t tmo;
    } poll_cfg_t;

endpackage

// File: rtl/apoll_cfg_reg.sv
// Configuration holding register for the auto-poll timer.
// Holds the timeout and the unit select. Loads them on a write strobe.
// Assumes: the reset timeout is fixed per instance by a parameter; the unit
// select resets to the normal unit.
module apoll_cfg_reg
    import apoll_pkg::*;
#(
    parameter poll_tmo_t RESET_TMO = '0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_we_i,
    input  poll_tmo_t cfg_tmo_i,
    input  logic      cfg_long_i,
    output poll_cfg_t cfg_o
);

    // Capture the new configuration on a write; reset to the instance default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o.tmo  <= RESET_TMO;
            cfg_o.unit <= UNIT_NORMAL;
        end else if (cfg_we_i) begin
            cfg_o.tmo  <= cfg_tmo_i;
            cfg_o.unit <= unit_sel_e'(cfg_long_i);
        end
    end

endmodule

// File: rtl/apoll_unit_div.sv
// Tick prescaler: turns MII tick enables into one pulse per cycle unit.
// A unit is NORM_TICKS or LONG_TICKS counted ticks, picked by the unit select.
// A restart clears the partial count, and a restart cycle gives no pulse.
// Assumes: the unit select changes only together with a restart.
module apoll_unit_div
    import apoll_pkg::*;
#(
    parameter int NORM_TICKS = 128,
    parameter int LONG_TICKS = 2048
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart_i,
    input  logic      tick_i,
    input  unit_sel_e unit_i,
    output logic      unit_pulse_o
);

    localparam int MAX_TICKS = (LONG_TICKS > NORM_TICKS) ? LONG_TICKS : NORM_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS);
    localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(NORM_TICKS - 1);
    localparam logic [CNT_W-1:0] LONG_LAST = CNT_W'(LONG_TICKS - 1);

    logic [CNT_W-1:0] tick_cnt;
    logic [CNT_W-1:0] last_val;
    logic             at_last;

    // Pick the terminal count for the selected unit.
    always_comb begin
        last_val = (unit_i == UNIT_LONG) ? LONG_LAST : NORM_LAST;
    end

    assign at_last      = tick_i && (tick_cnt == last_val);
    assign unit_pulse_o = at_last && !restart_i;

    // Count ticks within the current unit, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (restart_i) begin
            tick_cnt <= '0;
        end else if (tick_i) begin
            tick_cnt <= at_last ? '0 : tick_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/apoll_unit_cnt.sv
// Unit counter: counts unit pulses and fires when the timeout count is reached.
// A timeout of zero stops the count and never fires.
// Assumes: the timeout changes only together with a restart.
module apoll_unit_cnt
    import apoll_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart_i,
    input  logic      unit_pulse_i,
    input  poll_tmo_t tmo_i,
    output logic      fire_o
);

    poll_tmo_t unit_cnt;
    logic      enabled;
    logic      last_unit;

    assign enabled   = (tmo_i != '0);
    assign last_unit = (unit_cnt == (tmo_i - POLL_TMO_W'(1)));
    assign fire_o    = unit_pulse_i && enabled && last_unit;

    // Advance once per unit; wrap after the last unit of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_cnt <= '0;
        end else if (restart_i) begin
            unit_cnt <= '0;
        end else if (unit_pulse_i && enabled) begin
            unit_cnt <= last_unit ? '0 : unit_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/apoll_req_hold.sv
// Request holder: sets on any trigger and clears on acknowledge.
// A trigger in the same cycle as an acknowledge wins.
// Assumes: the DMA engine acknowledges at most once per request.
module apoll_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger_i,
    input  logic ack_i,
    output logic req_o
);

    // Merge triggers into one pending request until it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o <= 1'b0;
        end else begin
            req_o <= trigger_i || (req_o && !ack_i);
        end
    end

endmodule

// File: rtl/desc_poll_timer.sv
// Descriptor auto-poll timer, top level.
// Merges software poll demands with a periodic self-poll into one held
// request for a descriptor DMA engine.
// Assumes: tick_i is a one-cycle enable, synchronous to clk, at the MII rate;
// sw_poll_i and cfg_we_i are one-cycle strobes.
module desc_poll_timer
    import apoll_pkg::*;
#(
    parameter int        NORM_TICKS = 128,
    parameter int        LONG_TICKS = 2048,
    parameter poll_tmo_t RESET_TMO  = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sw_poll_i,
    input  logic                  tick_i,
    input  logic                  cfg_we_i,
    input  logic [POLL_TMO_W-1:0] cfg_tmo_i,
    input  logic                  cfg_long_i,
    input  logic                  ack_i,
    output logic                  poll_req_o
);

    poll_cfg_t cfg_q;
    poll_tmo_t tmo_q;
    logic      restart_w;
    logic      unit_pulse_w;
    logic      fire_w;
    logic      trigger_w;

    assign tmo_q     = cfg_q.tmo;
    assign restart_w = sw_poll_i || cfg_we_i;
    assign trigger_w = sw_poll_i || fire_w;

    apoll_cfg_reg #(
        .RESET_TMO (RESET_TMO)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we_i   (cfg_we_i),
        .cfg_tmo_i  (cfg_tmo_i),
        .cfg_long_i (cfg_long_i),
        .cfg_o      (cfg_q)
    );

    apoll_unit_div #(
        .NORM_TICKS (NORM_TICKS),
        .LONG_TICKS (LONG_TICKS)
    ) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_i    (restart_w),
        .tick_i       (tick_i),
        .unit_i       (cfg_q.unit),
        .unit_pulse_o (unit_pulse_w)
    );

    apoll_unit_cnt u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_i    (restart_w),
        .unit_pulse_i (unit_pulse_w),
        .tmo_i        (tmo_q),
        .fire_o       (fire_w)
    );

    apoll_req_hold u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .trigger_i (trigger_w),
        .ack_i     (ack_i),
        .req_o     (poll_req_o)
    );

endmodule

// File: rtl/apoll_checker.sv
// Property checker for the descriptor auto-poll timer, bound to the top.
// Assumes: fire and tmo are the periodic fire and the held timeout of the top.
module apoll_checker
    import apoll_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      sw_poll_i,
    input logic      tick_i,
    input logic      ack_i,
    input logic      poll_req_o,
    input logic      fire,
    input poll_tmo_t tmo
);

    // R1: the request is low on the cycle after any reset cycle.
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> !poll_req_o);

    // R2: a software demand raises the request next cycle.
    a_r2_sw_sets: assert property (@(posedge clk) disable iff (!rst_n)
        sw_poll_i |=> poll_req_o);

    // R3: an unacknowledged request stays high.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req_o && !ack_i) |=> poll_req_o);

    // R3: an acknowledge with no trigger clears the request.
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !sw_poll_i && !fire) |=> !poll_req_o);

    // R4: any trigger, even during an acknowledge, leaves the request high.
    a_r4_trigger_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (fire || sw_poll_i) |=> poll_req_o);

    // R5: a zero timeout never fires periodically.
    a_r5_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo == '0) |-> !fire);

    // R8: a periodic fire only happens on a tick cycle.
    a_r8_fire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> tick_i);

    // R10: every rising request has a trigger behind it (a config write alone is not one).
    a_r10_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(poll_req_o) |-> $past(sw_poll_i || fire));

endmodule

bind desc_poll_timer apoll_checker u_apoll_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_poll_i  (sw_poll_i),
    .tick_i     (tick_i),
    .ack_i      (ack_i),
    .poll_req_o (poll_req_o),
    .fire       (fire_w),
    .tmo        (tmo_q)
);

// File: tb/desc_poll_timer_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue the cycle in which each request edge is
// due, and a monitor compares every observed rising edge against the queue.
module desc_poll_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_poll = 1'b0;
    logic       tick = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_tmo = 4'd0;
    logic       cfg_long = 1'b0;
    logic       ack_man = 1'b0;
    logic       auto_ack = 1'b0;
    logic       ack;
    logic       poll_req;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rise_cnt = 0;
    int exp_q[$];
    logic prev_req = 1'b0;
    logic mon_on = 1'b0;

    assign ack = auto_ack ? poll_req : ack_man;

    desc_poll_timer #(
        .NORM_TICKS (128),
        .LONG_TICKS (2048),
        .RESET_TMO  (4'd1)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_poll_i  (sw_poll),
        .tick_i     (tick),
        .cfg_we_i   (cfg_we),
        .cfg_tmo_i  (cfg_tmo),
        .cfg_long_i (cfg_long),
        .ack_i      (ack),
        .poll_req_o (poll_req)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: match each rising edge of the request with the queued expectation.
    always @(negedge clk) begin
        if (mon_on) begin
            if (poll_req && !prev_req) begin
                rise_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "scoreboard unexpected request", cyc, -1);
                end else begin
                    chk(exp_q[0] == cyc, "scoreboard request cycle", cyc, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
            if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                chk(1'b0, "scoreboard missed request", cyc, exp_q[0]);
                void'(exp_q.pop_front());
            end
        end
        prev_req = poll_req;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: configuration write; k is the cycle it was driven in.
    task automatic cfg_write(input logic [3:0] t, input logic lng, output int k);
        cfg_we = 1'b1; cfg_tmo = t; cfg_long = lng; k = cyc;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: software demand; queues the request edge if asked to.
    task automatic sw_pulse(input bit push, output int k);
        sw_poll = 1'b1; k = cyc;
        if (push) exp_q.push_back(k + 1);
        @(negedge clk);
        sw_poll = 1'b0;
    endtask

    task automatic expect_periodic(input int base, input int period, input int n);
        for (int i = 1; i <= n; i++) exp_q.push_back(base + period * i);
    endtask

    initial begin
        int k;
        int j;
        int r0;
        @(negedge clk);
        tick = 1'b1;
        step(2);
        chk(poll_req == 1'b0, "R1 request low in reset", int'(poll_req), 0);
        step(1);
        chk(poll_req == 1'b0, "R1 request low in reset", int'(poll_req), 0);

        // R1: reset timeout 1, normal unit -> edges every 128 ticks.
        rst_n = 1'b1; r0 = cyc; auto_ack = 1'b1; mon_on = 1'b1;
        expect_periodic(r0, 128, 2);
        step(1);
        chk(poll_req == 1'b0, "R1 request low after reset", int'(poll_req), 0);
        step(299);

        // R5: timeout 0 stays silent.
        cfg_write(4'd0, 1'b0, k);
        r0 = rise_cnt;
        step(2000);
        chk(rise_cnt == r0, "R5 no periodic request at timeout 0", rise_cnt - r0, 0);

        // R2 / R3: demand, hold without acknowledge, then clear.
        auto_ack = 1'b0;
        sw_pulse(1'b1, k);
        chk(poll_req == 1'b1, "R2 demand raises request", int'(poll_req), 1);
        step(10);
        chk(poll_req == 1'b1, "R3 request held until acknowledge", int'(poll_req), 1);
        ack_man = 1'b1;
        step(1);
        ack_man = 1'b0;
        chk(poll_req == 1'b0, "R3 acknowledge clears request", int'(poll_req), 0);

        // R4: merged demands and trigger-with-acknowledge.
        r0 = rise_cnt;
        sw_pulse(1'b1, k);
        step(2);
        sw_pulse(1'b0, k);
        step(1);
        sw_pulse(1'b0, k);
        chk(poll_req == 1'b1, "R4 request pending after merged demands", int'(poll_req), 1);
        sw_poll = 1'b1; ack_man = 1'b1;
        step(1);
        sw_poll = 1'b0;
        chk(poll_req == 1'b1, "R4 trigger wins over acknowledge", int'(poll_req), 1);
        step(1);
        ack_man = 1'b0;
        chk(poll_req == 1'b0, "R4 single acknowledge clears merged request", int'(poll_req), 0);
        chk(rise_cnt - r0 == 1, "R4 merged demands give one request", rise_cnt - r0, 1);
        auto_ack = 1'b1;
        step(2);

        // R6 / R10: timeout 3, normal unit; the write itself raises nothing.
        cfg_write(4'd3, 1'b0, k);
        expect_periodic(k + 1, 384, 2);
        step(800);

        // R7: timeout 2, long unit.
        cfg_write(4'd2, 1'b1, k);
        expect_periodic(k + 1, 4096, 2);
        step(8200);

        // R8: no ticks, no progress; then exactly 128 more ticks.
        tick = 1'b0;
        cfg_write(4'd1, 1'b0, k);
        r0 = rise_cnt;
        step(1000);
        chk(rise_cnt == r0, "R8 countdown holds without ticks", rise_cnt - r0, 0);
        tick = 1'b1; j = cyc;
        exp_q.push_back(j + 128);
        step(140);
        cfg_write(4'd0, 1'b0, k);
        step(5);

        // R9: demand partway through a period restarts the countdown.
        cfg_write(4'd1, 1'b0, k);
        step(49);
        sw_pulse(1'b1, j);
        expect_periodic(j + 1, 128, 2);
        step(300);

        // R10: rewrite mid-period reloads from the new timeout.
        cfg_write(4'd2, 1'b0, k);
        step(199);
        cfg_write(4'd1, 1'b0, j);
        expect_periodic(j + 1, 128, 2);
        step(300);

        // R6: largest timeout with the long unit.
        cfg_write(4'd15, 1'b1, k);
        expect_periodic(k + 1, 30720, 1);
        step(30730);
        cfg_write(4'd0, 1'b0, k);
        step(10);

        chk(exp_q.size() == 0, "R6 all expected requests seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule